// File: doc/BRIEF.md
# Reversible Decimal Up/Down Counter

This block is a counter whose state is a chain of 4-bit BCD digits. Each digit stage can only step by one in either direction. A carry or borrow ripples from digit to digit inside a single clock cycle. The counter runs from zero up to a configurable upper limit `MAX_VALUE`, and that limit need not be a power of ten.

Stepping past either end wraps the counter. The block does not compute the wrapped value arithmetically. Instead it writes a constant digit pattern into all stages at once: all zeros when it wraps upward, and the BCD digits of the limit when it wraps downward.

A single design serves several roles through its parameters:
- a 6-digit instruction position (0 to 999999),
- a 3-digit nesting depth (0 to 999) with a zero flag,
- a 5-digit cell address (0 to 29999),
- a 3-digit byte value (0 to 255), which can be loaded in parallel and read back as binary.

Top module: `bcd_updown_counter`

## Requirements
- R1: After reset, or in the cycle after `clr_i` is high, every digit is 0. `clr_i` overrides `load_i`, `inc_i` and `dec_i`.
- R2: When `inc_i` is high and `dec_i`, `clr_i` and `load_i` are low, and the value is below `MAX_VALUE`, the value rises by exactly one in the next cycle. A digit stepping from 9 to 0 carries into the next higher digit in the same cycle.
- R3: When `dec_i` alone is high and the value is above 0, the value falls by exactly one in the next cycle. A digit stepping from 0 to 9 borrows from the next higher digit in the same cycle.
- R4: An increment alone while the value equals `MAX_VALUE` gives 0. No carry ever leaves the top digit.
- R5: A decrement alone while the value is 0 gives `MAX_VALUE`.
- R6: If `inc_i` and `dec_i` are both high, or both low, and `clr_i` and `load_i` are low, the digits keep their value.
- R7: With `load_i` high and `clr_i` low, the digits take `load_digits_i` in the next cycle, whatever the step inputs are.
- R8: `zero_o` is 1 exactly when the counter value is 0.
- R9: `value_bin_o` equals the decimal value of the digits, as an unsigned binary number.
- R10: Digit k sits at bits [4k+3:4k], with the least significant digit at bit 0. Each digit holds 0 to 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inc_i | input | 1 | Step up by one |
| dec_i | input | 1 | Step down by one |
| clr_i | input | 1 | Synchronous clear to zero |
| load_i | input | 1 | Parallel load of digits |
| load_digits_i | input | 4*DIGITS | BCD digits to load |
| digits_o | output | 4*DIGITS | Current BCD digits |
| zero_o | output | 1 | Value is zero |
| value_bin_o | output | $clog2(MAX_VALUE+1) | Value in binary |

## Verification
The byte configuration is driven through one full upward sweep from 0 past 255, and then one full downward sweep from 0 through 255 back past 0. Every single-carry and double-carry case is exercised, as well as both wrap points. This separates a correct ripple from one that stops after one digit, and separates the non-decimal wrap from a plain modulo-1000 wrap.

Simultaneous and idle step inputs, and loads combined with steps or a clear, test the priority order. A second instance in the address configuration loads values just below a long carry chain (09999), just above a long borrow chain (10000), and at both ends of its range. This exercises ripples across four digits and a limit whose top digit is 2.

// File: rtl/bcd_ctr_pkg.sv
package bcd_ctr_pkg;
  localparam int MAX_DIGITS = 8;
  localparam int MAX_W      = 4 * MAX_DIGITS;

  // Decimal digits of a non-negative integer, least significant digit in the low nibble.
  function automatic logic [MAX_W-1:0] int_to_bcd(input int unsigned v);
    logic [MAX_W-1:0] r;
    int unsigned      rest;
    r    = '0;
    rest = v;
    for (int i = 0; i < MAX_DIGITS; i++) begin
      r[4*i +: 4] = 4'(rest % 10);
      rest        = rest / 10;
    end
    return r;
  endfunction

  // One decimal step of a single digit; up selects +1, otherwise -1.
  function automatic logic [3:0] digit_step(input logic [3:0] d, input logic up);
    if (up) return (d == 4'd9) ? 4'd0 : d + 4'd1;
    else    return (d == 4'd0) ? 4'd9 : d - 4'd1;
  endfunction
endpackage

// File: rtl/bcd_digit_stage.sv
module bcd_digit_stage
  import bcd_ctr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       up_i,
  input  logic       dn_i,
  input  logic       wr_i,
  input  logic [3:0] wr_val_i,
  output logic [3:0] q_o,
  output logic       carry_o,
  output logic       borrow_o
);
  logic [3:0] q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= 4'd0;
    else if (wr_i) q <= wr_val_i;
    else if (up_i) q <= digit_step(q, 1'b1);
    else if (dn_i) q <= digit_step(q, 1'b0);
  end

  assign carry_o  = up_i && (q == 4'd9);
  assign borrow_o = dn_i && (q == 4'd0);
  assign q_o      = q;
endmodule

// File: rtl/bcd_to_bin.sv
module bcd_to_bin #(
  parameter int DIGITS = 3,
  parameter int BIN_W  = 8
) (
  input  logic [4*DIGITS-1:0] digits_i,
  output logic [BIN_W-1:0]    bin_o
);
  logic [31:0] acc;

  always_comb begin
    acc = 32'd0;
    for (int i = DIGITS - 1; i >= 0; i--) begin
      acc = acc * 32'd10 + 32'(digits_i[4*i +: 4]);
    end
    bin_o = BIN_W'(acc);
  end
endmodule

// File: rtl/bcd_updown_counter.sv
module bcd_updown_counter
  import bcd_ctr_pkg::*;
#(
  parameter int DIGITS    = 3,
  parameter int MAX_VALUE = 255,
  localparam int DW       = 4 * DIGITS,
  localparam int BIN_W    = $clog2(MAX_VALUE + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_i,
  input  logic             dec_i,
  input  logic             clr_i,
  input  logic             load_i,
  input  logic [DW-1:0]    load_digits_i,
  output logic [DW-1:0]    digits_o,
  output logic             zero_o,
  output logic [BIN_W-1:0] value_bin_o
);
  localparam logic [MAX_W-1:0] LIMIT_WIDE = int_to_bcd(MAX_VALUE);
  localparam logic [DW-1:0]    LIMIT_BCD  = LIMIT_WIDE[DW-1:0];

  // Named internal events, visible to the bound checker.
  logic          step_up, step_dn;
  logic          at_limit, at_zero;
  logic          wrap_up, wrap_dn;
  logic          write_all;
  logic [DW-1:0] write_val;
  logic [DIGITS-1:0] up_chain, dn_chain;
  logic [DIGITS-1:0] carry_vec, borrow_vec;
  logic          ripple_overflow;

  assign step_up  = inc_i && !dec_i && !clr_i && !load_i;
  assign step_dn  = dec_i && !inc_i && !clr_i && !load_i;
  assign at_limit = (digits_o == LIMIT_BCD);
  assign at_zero  = (digits_o == '0);
  assign wrap_up  = step_up && at_limit;
  assign wrap_dn  = step_dn && at_zero;

  // Wrap is performed as a digit-wise load of a constant pattern.
  assign write_all = clr_i || load_i || wrap_up || wrap_dn;
  always_comb begin
    if (clr_i)        write_val = '0;
    else if (load_i)  write_val = load_digits_i;
    else if (wrap_dn) write_val = LIMIT_BCD;
    else              write_val = '0;
  end

  assign up_chain[0] = step_up && !at_limit;
  assign dn_chain[0] = step_dn && !at_zero;

  for (genvar g = 0; g < DIGITS; g++) begin : g_digit
    bcd_digit_stage u_stage (
      .clk      (clk),
      .rst_n    (rst_n),
      .up_i     (up_chain[g]),
      .dn_i     (dn_chain[g]),
      .wr_i     (write_all),
      .wr_val_i (write_val[4*g +: 4]),
      .q_o      (digits_o[4*g +: 4]),
      .carry_o  (carry_vec[g]),
      .borrow_o (borrow_vec[g])
    );
    if (g < DIGITS - 1) begin : g_link
      assign up_chain[g+1] = carry_vec[g];
      assign dn_chain[g+1] = borrow_vec[g];
    end
  end

  // A ripple out of the top digit would mean the limit logic failed.
  assign ripple_overflow = carry_vec[DIGITS-1] || borrow_vec[DIGITS-1];

  assign zero_o = at_zero;

  bcd_to_bin #(.DIGITS(DIGITS), .BIN_W(BIN_W)) u_conv (
    .digits_i (digits_o),
    .bin_o    (value_bin_o)
  );
endmodule

// File: rtl/bcd_ctr_checker.sv
module bcd_ctr_checker #(
  parameter int DIGITS    = 3,
  parameter int MAX_VALUE = 255,
  parameter int BIN_W     = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                inc_i,
  input logic                dec_i,
  input logic                clr_i,
  input logic                load_i,
  input logic [4*DIGITS-1:0] load_digits_i,
  input logic [4*DIGITS-1:0] digits_o,
  input logic                zero_o,
  input logic [BIN_W-1:0]    value_bin_o,
  input logic                wrap_up,
  input logic                wrap_dn,
  input logic                ripple_overflow
);
  localparam logic [BIN_W-1:0] LIMIT = BIN_W'(MAX_VALUE);

  logic only_inc, only_dec;
  assign only_inc = inc_i && !dec_i && !clr_i && !load_i;
  assign only_dec = dec_i && !inc_i && !clr_i && !load_i;

  assert_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (digits_o == '0));

  assert_step_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (only_inc && value_bin_o != LIMIT) |=> (value_bin_o == $past(value_bin_o) + BIN_W'(1)));

  assert_step_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (only_dec && value_bin_o != '0) |=> (value_bin_o == $past(value_bin_o) - BIN_W'(1)));

  assert_wrap_top_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_up |=> (value_bin_o == '0));

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !ripple_overflow);

  assert_wrap_bottom_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_dn |=> (value_bin_o == LIMIT));

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !load_i && (inc_i == dec_i)) |=> $stable(digits_o));

  assert_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !clr_i) |=> (digits_o == $past(load_digits_i)));

  assert_zero_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    zero_o == (value_bin_o == '0));

  for (genvar g = 0; g < DIGITS; g++) begin : g_range
    assert_digit_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
      digits_o[4*g +: 4] <= 4'd9);
  end
endmodule

bind bcd_updown_counter bcd_ctr_checker #(
  .DIGITS(DIGITS), .MAX_VALUE(MAX_VALUE), .BIN_W(BIN_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .inc_i(inc_i), .dec_i(dec_i), .clr_i(clr_i),
  .load_i(load_i), .load_digits_i(load_digits_i), .digits_o(digits_o),
  .zero_o(zero_o), .value_bin_o(value_bin_o), .wrap_up(wrap_up),
  .wrap_dn(wrap_dn), .ripple_overflow(ripple_overflow)
);

// File: tb/bcd_updown_counter_test.sv
`timescale 1ns/1ps
module bcd_updown_counter_test;
  localparam int A_DIG = 3;
  localparam int A_MAX = 255;
  localparam int B_DIG = 5;
  localparam int B_MAX = 29999;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;

  // Byte configuration
  logic a_inc = 0, a_dec = 0, a_clr = 0, a_load = 0;
  logic [4*A_DIG-1:0] a_ld = '0, a_dig;
  logic a_zero;
  logic [7:0] a_bin;
  int a_exp = 0;

  // Address configuration
  logic b_inc = 0, b_dec = 0, b_clr = 0, b_load = 0;
  logic [4*B_DIG-1:0] b_ld = '0, b_dig;
  logic b_zero;
  logic [14:0] b_bin;
  int b_exp = 0;

  bcd_updown_counter #(.DIGITS(A_DIG), .MAX_VALUE(A_MAX)) uut (
    .clk(clk), .rst_n(rst_n), .inc_i(a_inc), .dec_i(a_dec), .clr_i(a_clr),
    .load_i(a_load), .load_digits_i(a_ld), .digits_o(a_dig),
    .zero_o(a_zero), .value_bin_o(a_bin));

  bcd_updown_counter #(.DIGITS(B_DIG), .MAX_VALUE(B_MAX)) uut_addr (
    .clk(clk), .rst_n(rst_n), .inc_i(b_inc), .dec_i(b_dec), .clr_i(b_clr),
    .load_i(b_load), .load_digits_i(b_ld), .digits_o(b_dig),
    .zero_o(b_zero), .value_bin_o(b_bin));

  // Decimal digits by repeated division (R10 layout: low digit at bit 0).
  function automatic logic [31:0] dec_digits(input int v);
    logic [31:0] r = '0;
    int rest = v;
    for (int k = 0; k < 8; k++) begin
      r[4*k +: 4] = 4'(rest % 10);
      rest = rest / 10;
    end
    return r;
  endfunction

  function automatic int next_val(input int cur, input int maxv, input logic i, input logic d,
                                  input logic c, input logic l, input int lv);
    if (c) return 0;
    if (l) return lv;
    if (i && !d) return (cur == maxv) ? 0 : cur + 1;
    if (d && !i) return (cur == 0) ? maxv : cur - 1;
    return cur;
  endfunction

  task automatic cmp(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step_a(input logic i, input logic d, input logic c, input logic l,
                        input int lv, input string req);
    a_inc = i; a_dec = d; a_clr = c; a_load = l; a_ld = dec_digits(lv)[4*A_DIG-1:0];
    @(negedge clk);
    a_exp = next_val(a_exp, A_MAX, i, d, c, l, lv);
    cmp(req, "digits", int'(a_dig), int'(dec_digits(a_exp)[4*A_DIG-1:0]));
    cmp("R9", "binary", int'(a_bin), a_exp);
    cmp("R8", "zero", int'(a_zero), int'(a_exp == 0));
  endtask

  task automatic step_b(input logic i, input logic d, input logic c, input logic l,
                        input int lv, input string req);
    b_inc = i; b_dec = d; b_clr = c; b_load = l; b_ld = dec_digits(lv)[4*B_DIG-1:0];
    @(negedge clk);
    b_exp = next_val(b_exp, B_MAX, i, d, c, l, lv);
    cmp(req, "digits", int'(b_dig), int'(dec_digits(b_exp)[4*B_DIG-1:0]));
    cmp("R9", "binary", int'(b_bin), b_exp);
    cmp("R8", "zero", int'(b_zero), int'(b_exp == 0));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    cmp("R1", "reset digits", int'(a_dig), 0);
    cmp("R8", "reset zero", int'(a_zero), 1);
    cmp("R1", "reset digits addr", int'(b_dig), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 and R4: full upward sweep past the limit
    for (int n = 0; n < A_MAX + 3; n++) step_a(1, 0, 0, 0, 0, "R2_R4");
    // R3 and R5: full downward sweep past zero
    step_a(0, 0, 1, 0, 0, "R1");
    for (int n = 0; n < A_MAX + 3; n++) step_a(0, 1, 0, 0, 0, "R3_R5");
    // R6: both strobes, then none
    step_a(1, 1, 0, 0, 0, "R6");
    step_a(0, 0, 0, 0, 0, "R6");
    // R7: load, load overriding steps
    step_a(0, 0, 0, 1, 199, "R7");
    step_a(1, 0, 0, 1, 90, "R7");
    step_a(0, 1, 0, 1, 100, "R7");
    step_a(0, 1, 0, 0, 0, "R3");
    // R1: clear overrides load and steps
    step_a(1, 0, 1, 1, 42, "R1");
    step_a(0, 1, 0, 0, 0, "R5");

    // Address configuration: long ripples and a limit with top digit 2
    step_b(0, 0, 0, 1, 9999, "R7");
    step_b(1, 0, 0, 0, 0, "R2");
    step_b(0, 1, 0, 0, 0, "R3");
    step_b(0, 0, 0, 1, 29998, "R7");
    step_b(1, 0, 0, 0, 0, "R2");
    step_b(1, 0, 0, 0, 0, "R4");
    step_b(0, 1, 0, 0, 0, "R5");
    step_b(0, 1, 0, 0, 0, "R3");
    step_b(1, 1, 0, 0, 0, "R6");
    step_b(0, 0, 1, 0, 0, "R1");
    for (int n = 0; n < 12; n++) step_b(1, 0, 0, 0, 0, "R2");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule